// File: doc/BRIEF.md
# DMA Channel Bus-Mode Sequencer

This block is the transfer engine of one DMA channel that shares a system bus with a CPU. Once it has been loaded with a source address, a destination address, a unit count, a unit size and two mode bits, it watches an active-low, level-sensitive transfer request. While that request is asserted and units remain, the channel asks for the bus and waits for the grant. It then moves data one unit at a time over a simple memory port that has a valid/ready handshake.

Two bus modes are supported. In cycle-steal mode the channel gives the bus back after every unit, so the CPU gets the bus between consecutive units. In burst mode the channel keeps the bus and runs units back to back. It lets go early only when the request is seen deasserted at a unit boundary. Each unit is either a read followed by a write (dual-address) or a single read cycle on the source side (single-address). The channel raises a sticky done flag when the count runs out.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `bus_req`, `mem_valid` and `done` are low. No bus request is made until a configuration has been loaded, even with `req_n` low.
- R2: A `cfg_load` pulse while the sequencer is idle latches all `cfg_*` inputs and clears `done`. A count of zero sets `done` on the next cycle, and no bus request follows.
- R3: With units remaining and `req_n` low, `bus_req` rises. `mem_valid` is never high unless both `bus_req` and `bus_gnt` are high.
- R4: In dual-address mode (`cfg_dual`=1) each unit is a read (`mem_write`=0) at the source address, followed in the next cycle by a write (`mem_write`=1) at the destination address. The write carries the data returned by that read.
- R5: In single-address mode (`cfg_dual`=0) each unit is exactly one read cycle at the source address, and the destination is never addressed.
- R6: Size codes 0, 1, 2 and 3 step the addresses by 1, 2, 4 and 4 bytes after each unit. Only the source steps in single-address mode. `mem_size` shows the latched code.
- R7: In cycle-steal mode (`cfg_burst`=0), `bus_req` is low in the cycle after each unit's final bus cycle completes. The next unit is not requested until `bus_gnt` has been seen low.
- R8: In burst mode (`cfg_burst`=1), with `req_n` still low and units remaining, the next unit's read is issued in the cycle right after the previous unit completes, and `bus_req` stays high.
- R9: In either mode, if `req_n` is high when a unit completes, `bus_req` drops in the next cycle and the channel idles with units remaining. When `req_n` goes low again, the transfer resumes at the next addresses.
- R10: The count drops by one per completed unit. `done` rises in the cycle after the last unit's final bus cycle, stays high until the next load, and no further request is made.
- R11: While `mem_ready` is low, the pending cycle holds `mem_valid` high and `mem_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load pulse for the configuration inputs |
| cfg_burst | input | 1 | 1 = burst mode, 0 = cycle-steal mode |
| cfg_dual | input | 1 | 1 = read-then-write units, 0 = single read cycle per unit |
| cfg_size | input | 2 | Unit size code: 0 byte, 1 word, 2/3 longword |
| cfg_src | input | AW | Start source address |
| cfg_dst | input | AW | Start destination address |
| cfg_count | input | CW | Number of units to move |
| req_n | input | 1 | Level-sensitive transfer request, active low |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Bus ownership granted |
| mem_valid | output | 1 | Bus cycle active |
| mem_write | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | AW | Bus cycle address |
| mem_size | output | 2 | Size code of the bus cycle |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Bus cycle completes this cycle |
| done | output | 1 | All units moved |

## Verification
The bench checks the gap between cycle-steal units. A sequencer that kept the request up, or re-requested before the grant fell, would show `bus_req` high right after a unit, or no cycle owned by the CPU. In burst mode it drops the request between the read and the write of a unit. A design that sampled the request mid-unit, ignored it, or failed to resume at the stepped addresses would leave the unit count or address trail wrong. Wait states, the zero-count load, the reserved size code and the exact cycle that `done` rises are each targeted: an off-by-one counter or a missing data latch shows up as an extra or missing cycle, a wrong step, or write data that does not match the preceding read.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD,
        ST_WR,
        ST_REL
    } seq_state_e;

    // byte step for a size code; the reserved code behaves as a longword
    function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    unit_bytes = 3'd1;
            2'd1:    unit_bytes = 3'd2;
            default: unit_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic [1:0]    size,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load)
            addr_d = load_val;
        else if (step)
            addr_d = addr_q + AW'(unit_bytes(size));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;
endmodule

// File: rtl/dma_chan_cnt.sv
module dma_chan_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec && cnt_q != '0)
            cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == ONE);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic          cfg_burst,
    input  logic          cfg_dual,
    input  logic [1:0]    cfg_size,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_count,
    input  logic          req_n,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          done
);
    localparam int NPTR = 2;   // pointer 0 = source, pointer 1 = destination

    typedef struct packed {
        seq_state_e    state;
        logic          armed;
        logic          burst;
        logic          dual;
        logic          done;
        logic [1:0]    size;
        logic [DW-1:0] data;
    } seq_t;

    seq_t q, n;
    logic load_en;
    logic unit_end;
    logic last_unit;
    logic burst_q;
    logic dual_q;
    logic [AW-1:0] ptr_init [NPTR];
    logic [AW-1:0] ptr      [NPTR];
    logic          ptr_step [NPTR];

    always_comb begin
        n        = q;
        load_en  = 1'b0;
        unit_end = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (cfg_load) begin
                    load_en = 1'b1;
                    n.burst = cfg_burst;
                    n.dual  = cfg_dual;
                    n.size  = cfg_size;
                    n.done  = (cfg_count == '0);
                    n.armed = (cfg_count != '0);
                end else if (q.armed && !req_n) begin
                    n.state = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_gnt) n.state = ST_RD;
            end
            ST_RD: begin
                if (mem_ready) begin
                    if (q.dual) begin
                        n.data  = mem_rdata;
                        n.state = ST_WR;
                    end else begin
                        unit_end = 1'b1;
                    end
                end
            end
            ST_WR: begin
                if (mem_ready) unit_end = 1'b1;
            end
            ST_REL: begin
                if (!bus_gnt) n.state = ST_IDLE;
            end
            default: n.state = ST_IDLE;
        endcase

        // unit boundary: end of count, continue the burst, or release
        if (unit_end) begin
            if (last_unit) begin
                n.done  = 1'b1;
                n.armed = 1'b0;
                n.state = ST_REL;
            end else if (q.burst && !req_n) begin
                n.state = ST_RD;
            end else begin
                n.state = ST_REL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign ptr_init[0] = cfg_src;
    assign ptr_init[1] = cfg_dst;
    assign ptr_step[0] = unit_end;
    assign ptr_step[1] = unit_end && q.dual;

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        dma_chan_addr #(.AW(AW)) u_addr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_en),
            .load_val (ptr_init[i]),
            .step     (ptr_step[i]),
            .size     (q.size),
            .addr     (ptr[i])
        );
    end

    dma_chan_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_en),
        .load_val (cfg_count),
        .dec      (unit_end),
        .last     (last_unit)
    );

    assign burst_q   = q.burst;
    assign dual_q    = q.dual;
    assign bus_req   = (q.state == ST_REQ) || (q.state == ST_RD) || (q.state == ST_WR);
    assign mem_valid = (q.state == ST_RD) || (q.state == ST_WR);
    assign mem_write = (q.state == ST_WR);
    assign mem_addr  = (q.state == ST_WR) ? ptr[1] : ptr[0];
    assign mem_size  = q.size;
    assign mem_wdata = q.data;
    assign done      = q.done;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_n,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          mem_valid,
    input logic          mem_write,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic          burst_q,
    input logic          dual_q,
    input logic          last_unit
);
    logic unit_done;
    assign unit_done = mem_valid && mem_ready && (mem_write || !dual_q);

    assert_valid_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (bus_req && bus_gnt));

    assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_q && mem_valid && !mem_write && mem_ready) |=> (mem_valid && mem_write));

    assert_single_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_q && mem_valid) |-> !mem_write);

    assert_steal_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_q && unit_done) |=> !bus_req);

    assert_burst_continue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_q && unit_done && !req_n && !last_unit) |=> (bus_req && mem_valid));

    assert_early_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && req_n) |=> !bus_req);

    assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && last_unit) |=> done);

    assert_wait_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_n     (req_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .done      (done),
    .burst_q   (burst_q),
    .dual_q    (dual_q),
    .last_unit (last_unit)
);

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam int HN = 16384;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic          cfg_burst = 1'b0;
    logic          cfg_dual = 1'b0;
    logic [1:0]    cfg_size = 2'd0;
    logic [AW-1:0] cfg_src = '0;
    logic [AW-1:0] cfg_dst = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          req_n = 1'b1;
    logic          bus_req;
    logic          bus_gnt;
    logic          mem_valid;
    logic          mem_write;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_ready;
    logic          done;

    int checks = 0;
    int fails  = 0;
    int ws_cfg = 0;
    int ws_left = 0;

    always #2.5 clk = ~clk;

    dma_chan_seq #(.AW(AW), .DW(DW), .CW(CW)) u_dma_chan_seq (
        .clk, .rst_n, .cfg_load, .cfg_burst, .cfg_dual, .cfg_size,
        .cfg_src, .cfg_dst, .cfg_count, .req_n, .bus_req, .bus_gnt,
        .mem_valid, .mem_write, .mem_addr, .mem_size, .mem_wdata,
        .mem_rdata, .mem_ready, .done
    );

    function automatic logic [31:0] pattern(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
    endfunction

    // bus arbiter model: grant follows request one cycle later
    always @(posedge clk or negedge rst_n)
        if (!rst_n) bus_gnt <= 1'b0;
        else        bus_gnt <= bus_req;

    // memory model with programmable wait states
    always @(posedge clk or negedge rst_n)
        if (!rst_n)                        ws_left <= 0;
        else if (!mem_valid || mem_ready)  ws_left <= ws_cfg;
        else                               ws_left <= ws_left - 1;

    assign mem_ready = mem_valid && (ws_left == 0);
    assign mem_rdata = pattern(mem_addr);

    // monitor, sampled mid-cycle
    int          cyc = 0;
    int          nlog = 0;
    int          done_cyc = -1;
    int          stab_err = 0;
    int          gnt_err = 0;
    logic        done_prev = 1'b0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic        h_req [HN];
    logic        h_gnt [HN];
    logic        h_val [HN];
    logic [31:0] l_addr [64];
    logic [31:0] l_data [64];
    logic        l_wr   [64];
    logic [1:0]  l_size [64];
    int          l_cyc  [64];

    always @(negedge clk) begin
        h_req[cyc % HN] = bus_req;
        h_gnt[cyc % HN] = bus_gnt;
        h_val[cyc % HN] = mem_valid;
        if (mem_valid && !(bus_req && bus_gnt)) gnt_err++;
        if (pend && (!mem_valid || mem_addr != pend_addr)) stab_err++;
        pend      = mem_valid && !mem_ready;
        pend_addr = mem_addr;
        if (mem_valid && mem_ready && nlog < 64) begin
            l_addr[nlog] = mem_addr;
            l_data[nlog] = mem_wdata;
            l_wr[nlog]   = mem_write;
            l_size[nlog] = mem_size;
            l_cyc[nlog]  = cyc;
            nlog++;
        end
        if (done && !done_prev) done_cyc = cyc;
        done_prev = done;
        cyc++;
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish (act=timeout exp=finish)");
        report();
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic burst, input logic dual, input logic [1:0] sz,
                        input logic [31:0] src, input logic [31:0] dst, input int cnt);
        repeat (4) @(negedge clk);
        nlog     = 0;
        done_cyc = -1;
        cfg_burst = burst; cfg_dual = dual; cfg_size = sz;
        cfg_src = src; cfg_dst = dst; cfg_count = CW'(cnt);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 bus_req in reset", 32'(bus_req), 0);
        rst_n = 1'b1;
        req_n = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1 bus_req unarmed", 32'(bus_req), 0);
        chk("R1 mem_valid unarmed", 32'(mem_valid), 0);
        chk("R1 done after reset", 32'(done), 0);
        req_n = 1'b1;
    endtask

    task automatic t_zero_count();
        load(1'b0, 1'b1, 2'd0, 32'h100, 32'h200, 0);
        chk("R2 done on zero count", 32'(done), 1);
        req_n = 1'b0;
        repeat (8) @(negedge clk);
        chk("R2 no request on zero count", 32'(bus_req), 0);
        chk("R2 no cycles on zero count", 32'(nlog), 0);
        req_n = 1'b1;
    endtask

    task automatic t_steal_dual();
        load(1'b0, 1'b1, 2'd1, 32'h1000, 32'h2000, 3);
        chk("R2 done cleared by load", 32'(done), 0);
        req_n = 1'b0;
        wait_done();
        req_n = 1'b1;
        chk("R4 steal cycle count", 32'(nlog), 6);
        for (int u = 0; u < 3; u++) begin
            chk("R4 read dir", 32'(l_wr[2*u]), 0);
            chk("R6 read addr word", l_addr[2*u], 32'h1000 + 32'(2*u));
            chk("R4 write dir", 32'(l_wr[2*u+1]), 1);
            chk("R6 write addr word", l_addr[2*u+1], 32'h2000 + 32'(2*u));
            chk("R4 write data", l_data[2*u+1], pattern(32'h1000 + 32'(2*u)));
            chk("R6 size code", 32'(l_size[2*u]), 1);
            chk("R7 req low after unit", 32'(h_req[(l_cyc[2*u+1] + 1) % HN]), 0);
            if (u < 2) begin
                chk("R7 cpu cycle between units", 32'(h_gnt[(l_cyc[2*u+1] + 2) % HN]), 0);
                chk("R7 next unit after release", 32'(l_cyc[2*u+2] > l_cyc[2*u+1] + 2), 1);
            end
        end
        chk("R10 done timing", 32'(done_cyc), 32'(l_cyc[5] + 1));
        chk("R3 valid only with grant", 32'(gnt_err), 0);
    endtask

    task automatic t_burst_dual();
        load(1'b1, 1'b1, 2'd2, 32'h4000, 32'h8000, 4);
        req_n = 1'b0;
        wait_done();
        chk("R8 burst cycle count", 32'(nlog), 8);
        for (int u = 0; u < 4; u++) begin
            chk("R6 long src step", l_addr[2*u], 32'h4000 + 32'(4*u));
            chk("R6 long dst step", l_addr[2*u+1], 32'h8000 + 32'(4*u));
            chk("R4 burst write data", l_data[2*u+1], pattern(32'h4000 + 32'(4*u)));
            if (u < 3) begin
                chk("R8 req held", 32'(h_req[(l_cyc[2*u+1] + 1) % HN]), 1);
                chk("R8 back to back", 32'(h_val[(l_cyc[2*u+1] + 1) % HN]), 1);
            end
        end
        chk("R10 done burst timing", 32'(done_cyc), 32'(l_cyc[7] + 1));
        repeat (10) @(negedge clk);
        chk("R10 no request after done", 32'(bus_req), 0);
        chk("R10 done sticky", 32'(done), 1);
        req_n = 1'b1;
    endtask

    task automatic t_single_burst();
        load(1'b1, 1'b0, 2'd0, 32'h0300, 32'h0900, 3);
        req_n = 1'b0;
        wait_done();
        req_n = 1'b1;
        chk("R5 single cycle count", 32'(nlog), 3);
        for (int u = 0; u < 3; u++) begin
            chk("R5 single is read", 32'(l_wr[u]), 0);
            chk("R5 single byte addr", l_addr[u], 32'h0300 + 32'(u));
        end
    endtask

    task automatic t_size3_steal();
        load(1'b0, 1'b0, 2'd3, 32'h0500, 32'h0700, 2);
        req_n = 1'b0;
        wait_done();
        req_n = 1'b1;
        chk("R6 code3 count", 32'(nlog), 2);
        chk("R6 code3 step", l_addr[1], 32'h0504);
        chk("R6 code3 size out", 32'(l_size[1]), 3);
        chk("R7 single steal release", 32'(h_req[(l_cyc[0] + 1) % HN]), 0);
    endtask

    task automatic t_early_release();
        ws_cfg = 2;
        load(1'b1, 1'b1, 2'd0, 32'h0A00, 32'h0B00, 5);
        req_n = 1'b0;
        wait (nlog >= 2);
        @(negedge clk);
        req_n = 1'b1;
        repeat (30) @(negedge clk);
        chk("R9 stopped after current unit", 32'(nlog), 4);
        chk("R9 bus released", 32'(bus_req), 0);
        chk("R9 not done", 32'(done), 0);
        chk("R9 release timing", 32'(h_req[(l_cyc[3] + 1) % HN]), 0);
        req_n = 1'b0;
        wait_done();
        req_n = 1'b1;
        chk("R9 total after resume", 32'(nlog), 10);
        chk("R9 resume src", l_addr[4], 32'h0A02);
        chk("R9 resume dst end", l_addr[9], 32'h0B04);
        chk("R11 address stable in waits", 32'(stab_err), 0);
        chk("R4 write data with waits", l_data[9], pattern(32'h0A04));
        ws_cfg = 0;
    endtask

    task automatic t_wait_steal();
        ws_cfg = 3;
        load(1'b0, 1'b1, 2'd1, 32'h0C00, 32'h0D00, 2);
        req_n = 1'b0;
        wait_done();
        req_n = 1'b1;
        chk("R11 wait count", 32'(nlog), 4);
        chk("R11 wait hold", 32'(stab_err), 0);
        chk("R11 data under waits", l_data[3], pattern(32'h0C02));
        chk("R3 grant rule overall", 32'(gnt_err), 0);
        ws_cfg = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_zero_count();
        t_steal_dual();
        t_burst_dual();
        t_single_burst();
        t_size3_steal();
        t_early_release();
        t_wait_steal();
        report();
        $finish;
    end
endmodule